// File: doc/BRIEF.md
# Message Buffer Interrupt Flag Bank

This block keeps one status flag per message buffer of a frame-based communication controller and folds the flags into two interrupt lines. Each buffer also holds three configuration bits: a direction bit (0 = receive, 1 = transmit), a bit that marks the buffer as a member of the receive FIFO, and an interrupt enable.

The flag carries a different meaning for each direction. On a receive buffer, 1 means the controller has stored a new frame outcome there. On a transmit buffer, 1 means the buffer is empty and the host may refill it. The protocol side raises flags with indexed event pulses. The host lowers a flag only by locking that buffer.

The block has a configuration state and a normal state. In the configuration state the host sets up each buffer. A write there also presets the buffer's flag from its direction. Protocol events are acted on only in the normal state.

Top module: `mbif_bank`

## Requirements
- R1: After reset all flags, both interrupt lines and all buffer configuration bits are 0, and `cfg_state_o` is 1.
- R2: A host write (`hw_en_i`) in the configuration state loads the indexed buffer's direction, FIFO and enable bits. In the same edge it sets the flag to 1 for a non-FIFO transmit buffer and to 0 otherwise.
- R3: In the configuration state, a flag that receives neither a write nor a lock keeps the value it had when the state was entered.
- R4: In the normal state, `rx_ev_i` sets the flag of the buffer at `rx_idx_i` if that buffer is a non-FIFO receive buffer. The flag is visible after the next rising edge. One pulse covers both a valid and an invalid frame.
- R5: In the normal state, `tx_ev_i` sets the flag of the buffer at `tx_idx_i` if that buffer is a non-FIFO transmit buffer.
- R6: A receive event aimed at a transmit buffer leaves the flag unchanged. So does a transmit event aimed at a receive buffer. A FIFO buffer's flag is never 1.
- R7: `rx_ev_i` and `tx_ev_i` have no effect while `cfg_state_o` is 1.
- R8: `lock_en_i` clears the flag of the buffer at `lock_idx_i`. If a set event hits the same buffer in the same cycle, the flag ends up 1.
- R9: `irq_rd_o` is the OR over receive buffers of flag AND enable. `irq_wr_o` is the same OR over transmit buffers. Both are registered, so each follows the flags one cycle later.
- R10: A host write in the normal state changes only the enable bit. Direction, FIFO bit and flag stay as they were.
- R11: `mode_cfg_i` enters the configuration state and `mode_run_i` leaves it, each effective at the next edge. If both are asserted together, `mode_cfg_i` takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_cfg_i | input | 1 | Enter configuration state |
| mode_run_i | input | 1 | Enter normal state |
| hw_en_i | input | 1 | Host write to a buffer's control bits |
| hw_idx_i | input | IDX_W | Buffer index of host write |
| hw_dir_i | input | 1 | Direction to write (1 = transmit) |
| hw_fifo_i | input | 1 | FIFO membership to write |
| hw_ien_i | input | 1 | Interrupt enable to write |
| lock_en_i | input | 1 | Host lock operation |
| lock_idx_i | input | IDX_W | Buffer index of lock |
| rx_ev_i | input | 1 | Frame reception finished (valid or invalid) |
| rx_idx_i | input | IDX_W | Buffer index of reception |
| tx_ev_i | input | 1 | Frame transmission finished |
| tx_idx_i | input | IDX_W | Buffer index of transmission |
| flag_o | output | NUM_BUF | Per-buffer status flags |
| irq_rd_o | output | 1 | Read interrupt (receive buffers) |
| irq_wr_o | output | 1 | Write interrupt (transmit buffers) |
| cfg_state_o | output | 1 | 1 while in configuration state |

## Verification
The bench uses the default build of 16 buffers with 4-bit indices. At this size every index value addresses a real buffer, so random indices reach both the lowest and the highest buffer. They also make same-buffer collisions between a lock, an event and a host write frequent enough to exercise the set-over-lock rule and the write-over-lock rule. A small buffer count also lets random direction and FIFO mixes produce every combination of receive and transmit buffers feeding the two interrupt lines.

// File: rtl/mbif_pkg.sv
// Package: shared types for the message buffer interrupt flag bank.
// Assumes: direction encoding 0 = receive, 1 = transmit.
package mbif_pkg;
    typedef struct packed {
        logic dir;   // 1 = transmit buffer
        logic fifo;  // member of receive FIFO
        logic ien;   // interrupt enable
    } buf_cfg_t;
endpackage

// File: rtl/mbif_slot.sv
// Module: one buffer's configuration bits and status flag.
// Assumes: hit inputs are already index-decoded by the parent; at most one
// write, one lock, one rx and one tx hit arrive per cycle.
module mbif_slot
    import mbif_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_state_i,
    input  logic     wr_hit_i,
    input  buf_cfg_t wr_cfg_i,
    input  logic     lock_hit_i,
    input  logic     rx_hit_i,
    input  logic     tx_hit_i,
    output logic     flag_o,
    output buf_cfg_t cfg_o
);
    buf_cfg_t cfg_q;
    logic     flag_q;
    logic     set_ev;

    // Protocol set event: normal state, non-FIFO, direction matches event.
    always_comb begin
        set_ev = !cfg_state_i && !cfg_q.fifo &&
                 ((rx_hit_i && !cfg_q.dir) || (tx_hit_i && cfg_q.dir));
    end

    // Configuration bits: full load in config state, enable only otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_hit_i) begin
            if (cfg_state_i) cfg_q     <= wr_cfg_i;
            else             cfg_q.ien <= wr_cfg_i.ien;
        end
    end

    // Flag: set event beats config preset, which beats host lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_ev) begin
            flag_q <= 1'b1;
        end else if (wr_hit_i && cfg_state_i) begin
            flag_q <= wr_cfg_i.dir && !wr_cfg_i.fifo;
        end else if (lock_hit_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign cfg_o  = cfg_q;
endmodule

// File: rtl/mbif_irq_merge.sv
// Module: registered reduction of enabled flags into read/write interrupts.
// Assumes: FIFO flags are always 0, so they need no masking here.
module mbif_irq_merge #(
    parameter int NUM_BUF = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BUF-1:0] flag_i,
    input  logic [NUM_BUF-1:0] ien_i,
    input  logic [NUM_BUF-1:0] dir_i,
    output logic               irq_rd_o,
    output logic               irq_wr_o
);
    logic [NUM_BUF-1:0] active;

    // Per-buffer interrupt request.
    always_comb active = flag_i & ien_i;

    // Register the two ORs, split by direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_rd_o <= 1'b0;
            irq_wr_o <= 1'b0;
        end else begin
            irq_rd_o <= |(active & ~dir_i);
            irq_wr_o <= |(active & dir_i);
        end
    end
endmodule

// File: rtl/mbif_bank.sv
// Module: top of the message buffer interrupt flag bank. Decodes indexed
// host and protocol operations, holds the mode state, instantiates slots.
// Assumes: indices beyond NUM_BUF-1 simply hit no buffer.
module mbif_bank
    import mbif_pkg::*;
#(
    parameter int NUM_BUF = 16,
    parameter int IDX_W   = $clog2(NUM_BUF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_cfg_i,
    input  logic               mode_run_i,
    input  logic               hw_en_i,
    input  logic [IDX_W-1:0]   hw_idx_i,
    input  logic               hw_dir_i,
    input  logic               hw_fifo_i,
    input  logic               hw_ien_i,
    input  logic               lock_en_i,
    input  logic [IDX_W-1:0]   lock_idx_i,
    input  logic               rx_ev_i,
    input  logic [IDX_W-1:0]   rx_idx_i,
    input  logic               tx_ev_i,
    input  logic [IDX_W-1:0]   tx_idx_i,
    output logic [NUM_BUF-1:0] flag_o,
    output logic               irq_rd_o,
    output logic               irq_wr_o,
    output logic               cfg_state_o
);
    logic               cfg_state;
    buf_cfg_t           wr_cfg;
    logic [NUM_BUF-1:0] dir_v;
    logic [NUM_BUF-1:0] fifo_v;
    logic [NUM_BUF-1:0] ien_v;

    // Mode state: configuration entry has precedence over leaving it.
    always_ff @(posedge clk) begin
        if (!rst_n)          cfg_state <= 1'b1;
        else if (mode_cfg_i) cfg_state <= 1'b1;
        else if (mode_run_i) cfg_state <= 1'b0;
    end

    // Pack host write data once for all slots.
    always_comb begin
        wr_cfg.dir  = hw_dir_i;
        wr_cfg.fifo = hw_fifo_i;
        wr_cfg.ien  = hw_ien_i;
    end

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
        buf_cfg_t slot_cfg;
        logic     wr_hit, lock_hit, rx_hit, tx_hit;

        // Index decode for this buffer.
        always_comb begin
            wr_hit   = hw_en_i   && (int'(hw_idx_i)   == g);
            lock_hit = lock_en_i && (int'(lock_idx_i) == g);
            rx_hit   = rx_ev_i   && (int'(rx_idx_i)   == g);
            tx_hit   = tx_ev_i   && (int'(tx_idx_i)   == g);
        end

        mbif_slot u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg_state_i (cfg_state),
            .wr_hit_i    (wr_hit),
            .wr_cfg_i    (wr_cfg),
            .lock_hit_i  (lock_hit),
            .rx_hit_i    (rx_hit),
            .tx_hit_i    (tx_hit),
            .flag_o      (flag_o[g]),
            .cfg_o       (slot_cfg)
        );

        assign dir_v[g]  = slot_cfg.dir;
        assign fifo_v[g] = slot_cfg.fifo;
        assign ien_v[g]  = slot_cfg.ien;
    end

    mbif_irq_merge #(.NUM_BUF(NUM_BUF)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_i   (flag_o),
        .ien_i    (ien_v),
        .dir_i    (dir_v),
        .irq_rd_o (irq_rd_o),
        .irq_wr_o (irq_wr_o)
    );

    assign cfg_state_o = cfg_state;
endmodule

// File: rtl/mbif_chk.sv
// Module: property checker for mbif_bank, attached by bind below.
// Assumes: connected to the top's ports and internal config vectors.
module mbif_chk #(
    parameter int NUM_BUF = 16,
    parameter int IDX_W   = $clog2(NUM_BUF)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_state,
    input logic [NUM_BUF-1:0] flag_o,
    input logic [NUM_BUF-1:0] dir_v,
    input logic [NUM_BUF-1:0] fifo_v,
    input logic [NUM_BUF-1:0] ien_v,
    input logic               hw_en_i,
    input logic [IDX_W-1:0]   hw_idx_i,
    input logic               lock_en_i,
    input logic [IDX_W-1:0]   lock_idx_i,
    input logic               rx_ev_i,
    input logic [IDX_W-1:0]   rx_idx_i,
    input logic               tx_ev_i,
    input logic [IDX_W-1:0]   tx_idx_i,
    input logic               irq_rd_o,
    input logic               irq_wr_o
);
    // R6
    fifo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o & fifo_v) == '0);

    // R4
    rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ev_i && !cfg_state && !dir_v[rx_idx_i] && !fifo_v[rx_idx_i]
        |=> flag_o[$past(rx_idx_i)]);

    // R5
    tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ev_i && !cfg_state && dir_v[tx_idx_i] && !fifo_v[tx_idx_i]
        |=> flag_o[$past(tx_idx_i)]);

    // R8
    lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_en_i && !(rx_ev_i && rx_idx_i == lock_idx_i)
        && !(tx_ev_i && tx_idx_i == lock_idx_i)
        && !(hw_en_i && cfg_state && hw_idx_i == lock_idx_i)
        |=> !flag_o[$past(lock_idx_i)]);

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_state && !hw_en_i && !lock_en_i |=> $stable(flag_o));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o & ien_v) == '0 |=> !irq_rd_o && !irq_wr_o);
endmodule

bind mbif_bank mbif_chk #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_mbif_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_state  (cfg_state),
    .flag_o     (flag_o),
    .dir_v      (dir_v),
    .fifo_v     (fifo_v),
    .ien_v      (ien_v),
    .hw_en_i    (hw_en_i),
    .hw_idx_i   (hw_idx_i),
    .lock_en_i  (lock_en_i),
    .lock_idx_i (lock_idx_i),
    .rx_ev_i    (rx_ev_i),
    .rx_idx_i   (rx_idx_i),
    .tx_ev_i    (tx_ev_i),
    .tx_idx_i   (tx_idx_i),
    .irq_rd_o   (irq_rd_o),
    .irq_wr_o   (irq_wr_o)
);

// File: tb/test_mbif_bank.sv
// Bench: directed corner cases plus seeded random traffic against a model.
module test_mbif_bank;
    localparam int NB = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_cfg_i = 0, mode_run_i = 0;
    logic          hw_en_i = 0, hw_dir_i = 0, hw_fifo_i = 0, hw_ien_i = 0;
    logic [IW-1:0] hw_idx_i = '0, lock_idx_i = '0, rx_idx_i = '0, tx_idx_i = '0;
    logic          lock_en_i = 0, rx_ev_i = 0, tx_ev_i = 0;
    logic [NB-1:0] flag_o;
    logic          irq_rd_o, irq_wr_o, cfg_state_o;

    int errors = 0;
    int checks = 0;

    logic [NB-1:0] m_flag = '0, m_dir = '0, m_fifo = '0, m_ien = '0;
    logic          m_cfg = 1'b1, m_rd = 1'b0, m_wr = 1'b0;

    always #5 clk = ~clk;

    mbif_bank #(.NUM_BUF(NB)) i_mbif_bank (.*);

    // Record one check result.
    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance the model by one edge with the inputs currently driven.
    task automatic tick();
        logic nrd = 0, nwr = 0;
        for (int i = 0; i < NB; i++)
            if (m_flag[i] && m_ien[i]) begin
                if (m_dir[i]) nwr = 1; else nrd = 1;
            end
        for (int i = 0; i < NB; i++) begin
            logic set, wr;
            set = !m_cfg && !m_fifo[i] &&
                  ((rx_ev_i && int'(rx_idx_i) == i && !m_dir[i]) ||
                   (tx_ev_i && int'(tx_idx_i) == i && m_dir[i]));
            wr = hw_en_i && int'(hw_idx_i) == i;
            if (set)             m_flag[i] = 1'b1;
            else if (wr && m_cfg) m_flag[i] = hw_dir_i && !hw_fifo_i;
            else if (lock_en_i && int'(lock_idx_i) == i) m_flag[i] = 1'b0;
            if (wr) begin
                if (m_cfg) begin
                    m_dir[i] = hw_dir_i; m_fifo[i] = hw_fifo_i;
                end
                m_ien[i] = hw_ien_i;
            end
        end
        if (mode_cfg_i)      m_cfg = 1'b1;
        else if (mode_run_i) m_cfg = 1'b0;
        @(posedge clk); #1;
        m_rd = nrd; m_wr = nwr;
        {mode_cfg_i, mode_run_i, hw_en_i, lock_en_i, rx_ev_i, tx_ev_i} = '0;
    endtask

    task automatic cmp_all(input string tag);
        chk(flag_o == m_flag, tag, flag_o, m_flag);
        chk(irq_rd_o == m_rd, tag, irq_rd_o, m_rd);
        chk(irq_wr_o == m_wr, tag, irq_wr_o, m_wr);
        chk(cfg_state_o == m_cfg, tag, cfg_state_o, m_cfg);
    endtask

    task automatic do_wr(input int idx, input bit d, input bit f, input bit e);
        @(negedge clk);
        hw_en_i = 1; hw_idx_i = IW'(idx); hw_dir_i = d; hw_fifo_i = f; hw_ien_i = e;
        tick();
    endtask
    task automatic do_lock(input int idx);
        @(negedge clk); lock_en_i = 1; lock_idx_i = IW'(idx); tick();
    endtask
    task automatic do_rx(input int idx);
        @(negedge clk); rx_ev_i = 1; rx_idx_i = IW'(idx); tick();
    endtask
    task automatic do_tx(input int idx);
        @(negedge clk); tx_ev_i = 1; tx_idx_i = IW'(idx); tick();
    endtask
    task automatic do_idle();
        @(negedge clk); tick();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk(flag_o == '0, "R1 flags", flag_o, 0);
        chk(!irq_rd_o && !irq_wr_o, "R1 irq", {irq_rd_o, irq_wr_o}, 0);
        chk(cfg_state_o, "R1 cfg", cfg_state_o, 1);

        // R2 configuration presets
        do_wr(0, 0, 0, 1);
        do_wr(1, 1, 0, 1);
        chk(flag_o[1] && !flag_o[0], "R2 preset", flag_o[1:0], 2'b10);
        do_wr(2, 0, 1, 1);
        chk(irq_wr_o, "R9 write irq", irq_wr_o, 1);
        do_wr(3, 1, 1, 1);
        do_wr(15, 1, 0, 0);
        chk(flag_o == 16'h8002, "R2 fifo tx no preset", flag_o, 16'h8002);
        // R11 both mode pulses: config wins
        @(negedge clk); mode_cfg_i = 1; mode_run_i = 1; tick();
        chk(cfg_state_o, "R11 cfg precedence", cfg_state_o, 1);
        // R7 events ignored in config state
        do_rx(0);
        chk(!flag_o[0], "R7 rx in cfg", flag_o[0], 0);
        @(negedge clk); mode_run_i = 1; tick();
        chk(!cfg_state_o, "R11 run", cfg_state_o, 0);

        // R4 receive set and R9 read irq one cycle later
        do_rx(0);
        chk(flag_o[0], "R4 rx set", flag_o[0], 1);
        chk(!irq_rd_o, "R9 rd not yet", irq_rd_o, 0);
        do_idle();
        chk(irq_rd_o, "R9 rd raised", irq_rd_o, 1);
        // R6 mismatched and FIFO events
        do_lock(1);
        chk(!flag_o[1], "R8 lock clear", flag_o[1], 0);
        do_rx(1);
        chk(!flag_o[1], "R6 rx to tx buf", flag_o[1], 0);
        do_rx(2);
        chk(!flag_o[2], "R6 rx to fifo", flag_o[2], 0);
        do_tx(3);
        chk(!flag_o[3], "R6 tx to fifo", flag_o[3], 0);
        do_tx(0);
        chk(flag_o[0], "R6 tx to rx buf unchanged", flag_o[0], 1);
        // R5 transmit set
        do_tx(1);
        chk(flag_o[1], "R5 tx set", flag_o[1], 1);
        // R8 set wins over lock in the same cycle
        @(negedge clk); lock_en_i = 1; lock_idx_i = 0; rx_ev_i = 1; rx_idx_i = 0; tick();
        chk(flag_o[0], "R8 set beats lock", flag_o[0], 1);
        // R10 normal-state write keeps direction and flag
        do_lock(0);
        do_wr(0, 1, 0, 1);
        do_tx(0);
        chk(!flag_o[0], "R10 dir kept", flag_o[0], 0);
        do_rx(0);
        chk(flag_o[0], "R10 still receive", flag_o[0], 1);
        // R3 entering config keeps flags
        @(negedge clk); mode_cfg_i = 1; tick();
        repeat (3) do_idle();
        chk(flag_o == m_flag && flag_o[15] && flag_o[0], "R3 hold", flag_o, m_flag);
        cmp_all("R1/R2/R3 directed model");

        // Seeded random traffic compared every cycle
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            hw_en_i = ($urandom % 6) == 0;  hw_idx_i = IW'($urandom);
            hw_dir_i = $urandom; hw_fifo_i = ($urandom % 4) == 0; hw_ien_i = $urandom;
            lock_en_i = ($urandom % 3) == 0; lock_idx_i = IW'($urandom);
            rx_ev_i = $urandom; rx_idx_i = IW'($urandom);
            tx_ev_i = $urandom; tx_idx_i = IW'($urandom);
            mode_cfg_i = ($urandom % 40) == 0; mode_run_i = ($urandom % 10) == 0;
            tick();
            cmp_all("R4/R5/R6/R7/R8/R9/R10/R11 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule